// File: doc/BRIEF.md
# Card Activity LED Blink Controller

This block drives the activity indicator of a flash-media card reader. Each time the surrounding logic signals a media access with a one-cycle pulse, the block keeps the LED blinking at a programmable rate. Blinking continues for a programmable hold-over time after the most recent access. The LED then returns to its inactive level. Both times are counted in 50 ms steps. An internal prescaler derives those steps from a free-running system tick. The number of ticks per step is a parameter.

The blink interval and the hold-over duration are 8-bit inputs counted in steps. Their usual power-on settings are 02h (100 ms interval) and 28h (2 s hold-over). A polarity input selects whether the pin is driven high or low for a lit LED. The output pin is registered, so a polarity change appears on the pin one clock later. It leaves the hold-over countdown unchanged.

All pins are plain level or strobe controls. There is no data stream and so no valid/ready handshake: an access pulse is never refused and never queued.

Top module: `card_led_blinker`

## Requirements
- R1: During reset and in the first cycle after it, `led_out` is 0, given `led_active_low` = 0; the block is idle.
- R2: A 50 ms step occurs on every `TICKS_PER_STEP`-th cycle in which `sys_tick` is 1, counted from reset. Cycles with `sys_tick` = 0 advance nothing.
- R3: An `access_pulse` reloads the hold-over countdown with `hold_steps`. With `hold_steps` = 0 the LED stays inactive.
- R4: After an access, the LED turns on at the first step. It then toggles every `blink_steps` steps, and a `blink_steps` of 0 behaves as 1. On step k after the access (k < hold), the LED is on exactly when floor((k-1)/interval) is even.
- R5: Once `hold_steps` steps have passed since the last access, the LED goes to its inactive level. The interval counter is cleared, so the next burst starts lit at its first step.
- R6: An access during a burst extends the hold-over without restarting the blink phase. The interval counter keeps counting from where it was.
- R7: `led_out` equals the lit state XOR `led_active_low` (1 = active-low, 0 = active-high). A polarity change shows on the pin one clock later and does not alter the countdown.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sys_tick | input | 1 | Free-running tick strobe feeding the step prescaler |
| access_pulse | input | 1 | One-cycle strobe per media access |
| blink_steps | input | 8 | Blink half-period in 50 ms steps (0 acts as 1) |
| hold_steps | input | 8 | Blink hold-over after the last access, in 50 ms steps |
| led_active_low | input | 1 | 1: lit LED drives the pin low; 0: drives it high |
| led_out | output | 1 | Registered LED pin level |

## Verification
A step is the cycle in which the tick that completes a prescaler count arrives. The countdown and the lit state settle on the following rising edge, and `led_out` follows one edge later, two edges after the step. A polarity change reaches `led_out` one edge after it is applied. The bench sends ticks in groups of `TICKS_PER_STEP` pulses with idle cycles after each group. It samples on the falling edge three rising edges after each step, which is past every register on the path and well before the next step. The polarity check samples one falling edge after the change.

// File: rtl/card_led_pkg.sv
package card_led_pkg;
  // Width of every step-counted quantity (interval, hold-over, counters).
  localparam int unsigned STEP_W = 8;
  typedef logic [STEP_W-1:0] steps_t;
endpackage

// File: rtl/card_led_prescaler.sv
module card_led_prescaler #(
  parameter int unsigned TICKS_PER_STEP = 50
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sys_tick,
  output logic step
);
  generate
    if (TICKS_PER_STEP <= 1) begin : g_direct
      assign step = sys_tick;
    end else begin : g_count
      localparam int unsigned CW = $clog2(TICKS_PER_STEP);
      localparam logic [CW-1:0] LAST = CW'(TICKS_PER_STEP - 1);
      logic [CW-1:0] cnt;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt <= '0;
        else if (sys_tick) cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
      end

      assign step = sys_tick && (cnt == LAST);

      // R2: idle cycles leave the prescaler untouched
      assert_idle_no_count_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !sys_tick |=> $stable(cnt));
      // R2: count never passes the last tick of a step
      assert_count_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LAST);
    end
  endgenerate
endmodule

// File: rtl/card_led_holdover.sv
module card_led_holdover
  import card_led_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   access,
  input  logic   step,
  input  steps_t duration,
  output logic   active
);
  steps_t remain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) remain <= '0;
    else if (access) remain <= duration;
    else if (step && remain != '0) remain <= remain - steps_t'(1);
  end

  assign active = (remain != '0);

  // R3: an access loads the programmed duration
  assert_reload_R3: assert property (@(posedge clk) disable iff (!rst_n)
    access |=> remain == $past(duration));
  // R2: without a step or access the countdown holds
  assert_hold_without_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!access && !step) |=> $stable(remain));
  // R5: an expired countdown stays expired until the next access
  assert_stays_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!access && remain == '0) |=> remain == '0);
endmodule

// File: rtl/card_led_toggler.sv
module card_led_toggler
  import card_led_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   step,
  input  logic   active,
  input  steps_t interval,
  output logic   led_on
);
  steps_t left;
  steps_t reload;

  assign reload = (interval == '0) ? steps_t'(1) : interval;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left   <= '0;
      led_on <= 1'b0;
    end else if (!active) begin
      left   <= '0;
      led_on <= 1'b0;
    end else if (step) begin
      if (left <= steps_t'(1)) begin
        led_on <= ~led_on;
        left   <= reload;
      end else begin
        left <= left - steps_t'(1);
      end
    end
  end

  // R5: idle means dark and a cleared interval counter
  assert_dark_when_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> (!led_on && left == '0));
  // R4: the lit state only changes on a step while blinking
  assert_toggle_on_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !step) |=> $stable(led_on));
  // R4: a fresh burst lights the LED on its first step
  assert_first_step_lights_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (active && step && left == '0) |=> led_on);
endmodule

// File: rtl/card_led_blinker.sv
module card_led_blinker
  import card_led_pkg::*;
#(
  parameter int unsigned TICKS_PER_STEP = 50
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sys_tick,
  input  logic       access_pulse,
  input  logic [7:0] blink_steps,
  input  logic [7:0] hold_steps,
  input  logic       led_active_low,
  output logic       led_out
);
  logic step;
  logic active;
  logic led_on;

  card_led_prescaler #(.TICKS_PER_STEP(TICKS_PER_STEP)) u_prescaler (
    .clk     (clk),
    .rst_n   (rst_n),
    .sys_tick(sys_tick),
    .step    (step)
  );

  card_led_holdover u_holdover (
    .clk     (clk),
    .rst_n   (rst_n),
    .access  (access_pulse),
    .step    (step),
    .duration(steps_t'(hold_steps)),
    .active  (active)
  );

  card_led_toggler u_toggler (
    .clk     (clk),
    .rst_n   (rst_n),
    .step    (step),
    .active  (active),
    .interval(steps_t'(blink_steps)),
    .led_on  (led_on)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) led_out <= 1'b0;
    else        led_out <= led_on ^ led_active_low;
  end

  // R7: a dark LED puts the selected inactive level on the pin next clock
  assert_polarity_dark_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !led_on |=> led_out == $past(led_active_low));
  // R7: a lit LED puts the selected active level on the pin next clock
  assert_polarity_lit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    led_on |=> led_out == !$past(led_active_low));
endmodule

// File: tb/card_led_blinker_tb.sv
module card_led_blinker_tb;
  localparam int unsigned DIV = 3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sys_tick = 1'b0;
  logic       access_pulse = 1'b0;
  logic [7:0] blink_steps = 8'd0;
  logic [7:0] hold_steps = 8'd0;
  logic       led_active_low = 1'b0;
  logic       led_out;

  int checks = 0;
  int fails = 0;

  always #4 clk = ~clk;

  card_led_blinker #(.TICKS_PER_STEP(DIV)) u_dut (
    .clk           (clk),
    .rst_n         (rst_n),
    .sys_tick      (sys_tick),
    .access_pulse  (access_pulse),
    .blink_steps   (blink_steps),
    .hold_steps    (hold_steps),
    .led_active_low(led_active_low),
    .led_out       (led_out)
  );

  task automatic chk(input string req, input logic got, input logic exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: led_out=%b expected=%b at %0t", req, got, exp, $time);
    end
  endtask

  // One clock: drive at falling edge, hold across the next rising edge.
  task automatic cyc(input logic t, input logic a);
    sys_tick = t;
    access_pulse = a;
    @(negedge clk);
    sys_tick = 1'b0;
    access_pulse = 1'b0;
  endtask

  // One full step: DIV ticks, then idle so the pin has settled.
  task automatic step_group();
    for (int i = 0; i < DIV; i++) begin
      cyc(1'b1, 1'b0);
      cyc(1'b0, 1'b0);
    end
    cyc(1'b0, 1'b0);
    cyc(1'b0, 1'b0);
  endtask

  // Lit state on step k after the last access (R4, R5).
  function automatic logic exp_lit(input int k, input int ivl, input int hold);
    int ie;
    ie = (ivl == 0) ? 1 : ivl;
    if (k >= hold) return 1'b0;
    return (((k - 1) / ie) % 2) == 0;
  endfunction

  task automatic access_now();
    cyc(1'b0, 1'b1);
    cyc(1'b0, 1'b0);
    cyc(1'b0, 1'b0);
  endtask

  initial begin
    int dl[6] = '{0, 1, 2, 3, 5, 7};
    @(negedge clk);
    chk("R1 in reset", led_out, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after reset", led_out, 1'b0);

    // R2: fewer than DIV ticks produce no step, even with many idle cycles
    blink_steps = 8'd1;
    hold_steps = 8'd5;
    access_now();
    chk("R3 access before step", led_out, 1'b0);
    for (int i = 0; i < DIV - 1; i++) cyc(1'b1, 1'b0);
    for (int i = 0; i < 10; i++) cyc(1'b0, 1'b0);
    chk("R2 partial step", led_out, 1'b0);
    cyc(1'b1, 1'b0);
    cyc(1'b0, 1'b0);
    cyc(1'b0, 1'b0);
    cyc(1'b0, 1'b0);
    chk("R2 step completes", led_out, 1'b1);
    for (int k = 2; k <= 7; k++) begin
      step_group();
      chk("R4 R5 after R2 burst", led_out, exp_lit(k, 1, 5));
    end

    // Sweep: polarity x interval x hold-over
    for (int p = 0; p < 2; p++) begin
      for (int ivl = 0; ivl < 4; ivl++) begin
        for (int di = 0; di < 6; di++) begin
          led_active_low = p[0];
          blink_steps = 8'(ivl);
          hold_steps = 8'(dl[di]);
          cyc(1'b0, 1'b0);
          access_now();
          chk("R3 R7 idle after access", led_out, p[0]);
          for (int k = 1; k <= dl[di] + 2; k++) begin
            step_group();
            if (dl[di] == 0)
              chk("R3 zero hold stays dark", led_out, p[0]);
            else if (k >= dl[di])
              chk("R5 burst over", led_out, p[0]);
            else
              chk("R4 R7 blink pattern", led_out, exp_lit(k, ivl, dl[di]) ^ p[0]);
          end
        end
      end
    end

    // R6: re-access mid-burst keeps the blink phase
    led_active_low = 1'b0;
    blink_steps = 8'd2;
    hold_steps = 8'd8;
    cyc(1'b0, 1'b0);
    access_now();
    for (int k = 1; k <= 3; k++) begin
      step_group();
      chk("R4 before retrigger", led_out, exp_lit(k, 2, 8));
    end
    access_now();
    for (int j = 1; j <= 10; j++) begin
      step_group();
      chk("R6 retrigger phase", led_out, (j < 8) ? exp_lit(3 + j, 2, 255) : 1'b0);
    end

    // R7: polarity flip mid-burst, countdown undisturbed
    blink_steps = 8'd2;
    hold_steps = 8'd6;
    cyc(1'b0, 1'b0);
    access_now();
    for (int k = 1; k <= 3; k++) begin
      step_group();
      chk("R7 before flip", led_out, exp_lit(k, 2, 6));
    end
    led_active_low = 1'b1;
    @(negedge clk);
    chk("R7 flip next clock", led_out, exp_lit(3, 2, 6) ^ 1'b1);
    for (int k = 4; k <= 8; k++) begin
      step_group();
      chk("R7 after flip", led_out, exp_lit(k, 2, 6) ^ 1'b1);
    end

    $display("test done: total=%0d bad=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(8 * 150000);
    fails++;
    checks++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", checks, fails);
    $finish;
  end
endmodule